// File: doc/BRIEF.md
# RV32I Instruction Field Decoder

This block takes one 32-bit RV32I instruction word per clock and breaks it into the pieces that the rest of a small core needs. It sorts the word into one of the six base encoding formats using the low seven opcode bits. It extracts the destination and source register indices. It produces a 4-bit operation code in the ALU's own encoding, plus a negate-b flag and a signed-compare flag. It also builds a 32-bit immediate. The immediate is sign-extended and placed at its final bit position: branch and jump offsets already carry their zero low bit, and upper immediates already carry their twelve zero bits. No stage downstream has to shift anything.

Every output is registered, so results appear one clock after the word is presented. A synchronous active-high reset clears all outputs. Opcodes outside the supported set are flagged as illegal, and every other field is then forced to zero. Register indices that the format does not define are driven as zero, so downstream hazard logic never sees stray values.

Top module: `rv_field_decoder`

## Requirements
- R1: Opcode bits [6:0] select the format code `fmt_o`: 0110011 gives R (1); 0010011, 0000011 and 1100111 give I (2); 0100011 gives S (3); 1100011 gives B (4); 0110111 and 0010111 give U (5); 1101111 gives J (6). Code 0 means no valid format.
- R2: `rd_o` is bits [11:7] for R, I, U and J formats. `rs1_o` is bits [19:15] for R, I, S and B formats. `rs2_o` is bits [24:20] for R, S and B formats. Any index that the format does not define is zero.
- R3: For the I format, the immediate is bits [31:20] sign-extended from bit 31. For shift-immediate forms this is the raw 12-bit field, with the shift amount in imm[4:0].
- R4: For the S format, the immediate is {bits[31:25], bits[11:7]} sign-extended.
- R5: For the B format, the immediate is {bit31, bit7, bits[30:25], bits[11:8], 0} sign-extended, so imm[0] is always 0.
- R6: For the J format, the immediate is {bit31, bits[19:12], bit20, bits[30:21], 0} sign-extended, so imm[0] is always 0.
- R7: For the U format, the immediate is {bits[31:12], 12 zeros}. For the R format, the immediate is zero.
- R8: Any opcode not listed in R1 sets `illegal_o`. In that case all other outputs are zero and `fmt_o` is 0.
- R9: For opcode 0110011, funct3 (bits [14:12]) selects the ALU code as follows: 000 gives add 0000; 001 gives shift-left 0111; 010 and 011 give compare 0010; 100 gives xor 0101; 101 gives shift-right 1000, or 1001 when bit 30 is set; 110 gives or 0100; 111 gives and 0011. With funct3 000 and bit 30 set, the code is still add and `neg_b_o` is 1. No other funct7 bit is consulted.
- R10: Opcode 0010011 uses the same funct3 mapping as R9, with two differences: bit 30 only selects arithmetic versus logical shift right, and `neg_b_o` is always 0. `cmp_signed_o` is 1 exactly when funct3 is 010, for both opcodes 0010011 and 0110011.
- R11: Every other legal opcode outputs ALU code 0000 with `neg_b_o` and `cmp_signed_o` at 0.
- R12: Outputs reflect the word sampled at the previous rising clock edge. While `rst_i` is high at an edge, all outputs become zero with `illegal_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| alu_op_o | output | 4 | ALU operation code |
| neg_b_o | output | 1 | ALU should negate operand b (subtract) |
| cmp_signed_o | output | 1 | Comparison treats operands as signed |
| imm_o | output | 32 | Positioned, sign-extended immediate |
| fmt_o | output | 3 | Format code (0 none, 1 R, 2 I, 3 S, 4 B, 5 U, 6 J) |
| illegal_o | output | 1 | Opcode not recognised |

## Verification
The assertions assume that `instr_i` holds a defined value at every rising edge once reset is released. They relate each output only to the word sampled one edge earlier, and only when reset was low at that earlier edge. The stimulus drives `instr_i` on falling edges only and never leaves it undriven. It mixes directed encodings (negative offsets, subtract, arithmetic shifts, both compare flavours, unlisted opcodes) with random upper bits under every listed opcode and several unlisted ones. A reset in the middle of the run confirms that the outputs clear and that decoding resumes.

// File: rtl/rv_dec_pkg.sv
package rv_dec_pkg;
  parameter int ILEN   = 32;
  parameter int RIDX_W = 5;
  parameter int ALU_W  = 4;
  parameter int FMT_W  = 3;
  parameter int OPC_W  = 7;

  typedef enum logic [FMT_W-1:0] {
    FMT_NONE = 3'd0,
    FMT_R    = 3'd1,
    FMT_I    = 3'd2,
    FMT_S    = 3'd3,
    FMT_B    = 3'd4,
    FMT_U    = 3'd5,
    FMT_J    = 3'd6
  } fmt_e;

  localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;

  localparam logic [ALU_W-1:0] ALU_ADD = 4'b0000;
  localparam logic [ALU_W-1:0] ALU_CMP = 4'b0010;
  localparam logic [ALU_W-1:0] ALU_AND = 4'b0011;
  localparam logic [ALU_W-1:0] ALU_OR  = 4'b0100;
  localparam logic [ALU_W-1:0] ALU_XOR = 4'b0101;
  localparam logic [ALU_W-1:0] ALU_SLL = 4'b0111;
  localparam logic [ALU_W-1:0] ALU_SRL = 4'b1000;
  localparam logic [ALU_W-1:0] ALU_SRA = 4'b1001;
endpackage

// File: rtl/rv_fmt_classify.sv
module rv_fmt_classify
  import rv_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output fmt_e             fmt_o,
  output logic             is_op_o,
  output logic             is_opimm_o
);
  always_comb begin
    is_op_o    = 1'b0;
    is_opimm_o = 1'b0;
    case (opcode_i)
      OPC_OP:     begin fmt_o = FMT_R; is_op_o = 1'b1; end
      OPC_OPIMM:  begin fmt_o = FMT_I; is_opimm_o = 1'b1; end
      OPC_LOAD,
      OPC_JALR:   fmt_o = FMT_I;
      OPC_STORE:  fmt_o = FMT_S;
      OPC_BRANCH: fmt_o = FMT_B;
      OPC_LUI,
      OPC_AUIPC:  fmt_o = FMT_U;
      OPC_JAL:    fmt_o = FMT_J;
      default:    fmt_o = FMT_NONE;
    endcase
  end
endmodule

// File: rtl/rv_reg_fields.sv
module rv_reg_fields
  import rv_dec_pkg::*;
#(
  parameter int NFIELD = 3
)(
  input  logic [24:7]       body_i,
  input  fmt_e              fmt_i,
  output logic [RIDX_W-1:0] idx_o [NFIELD]
);
  // field 0 = rd, 1 = rs1, 2 = rs2
  localparam int LSB [NFIELD] = '{7, 15, 20};

  function automatic logic uses(input int f, input fmt_e fm);
    case (f)
      0:       return fm inside {FMT_R, FMT_I, FMT_U, FMT_J};
      1:       return fm inside {FMT_R, FMT_I, FMT_S, FMT_B};
      default: return fm inside {FMT_R, FMT_S, FMT_B};
    endcase
  endfunction

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    localparam int OFS = LSB[g] - 7;
    always_comb
      idx_o[g] = uses(g, fmt_i) ? body_i[OFS+7 +: RIDX_W] : '0;
  end
endmodule

// File: rtl/rv_imm_build.sv
module rv_imm_build
  import rv_dec_pkg::*;
(
  input  logic [ILEN-1:7] ins_i,
  input  fmt_e            fmt_i,
  output logic [ILEN-1:0] imm_o
);
  logic s;
  assign s = ins_i[31];

  always_comb begin
    case (fmt_i)
      FMT_I: imm_o = {{20{s}}, ins_i[31:20]};
      FMT_S: imm_o = {{20{s}}, ins_i[31:25], ins_i[11:7]};
      FMT_B: imm_o = {{19{s}}, s, ins_i[7], ins_i[30:25], ins_i[11:8], 1'b0};
      FMT_U: imm_o = {ins_i[31:12], 12'b0};
      FMT_J: imm_o = {{11{s}}, s, ins_i[19:12], ins_i[20], ins_i[30:21], 1'b0};
      default: imm_o = '0;
    endcase
  end
endmodule

// File: rtl/rv_alu_map.sv
module rv_alu_map
  import rv_dec_pkg::*;
(
  input  logic             is_op_i,
  input  logic             is_opimm_i,
  input  logic [2:0]       funct3_i,
  input  logic             alt_i,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             neg_b_o,
  output logic             cmp_signed_o
);
  logic arith;
  assign arith = is_op_i | is_opimm_i;

  always_comb begin
    alu_op_o     = ALU_ADD;
    neg_b_o      = 1'b0;
    cmp_signed_o = 1'b0;
    if (arith) begin
      case (funct3_i)
        3'b000: begin
          alu_op_o = ALU_ADD;
          neg_b_o  = is_op_i & alt_i;
        end
        3'b001: alu_op_o = ALU_SLL;
        3'b010: begin
          alu_op_o     = ALU_CMP;
          cmp_signed_o = 1'b1;
        end
        3'b011: alu_op_o = ALU_CMP;
        3'b100: alu_op_o = ALU_XOR;
        3'b101: alu_op_o = alt_i ? ALU_SRA : ALU_SRL;
        3'b110: alu_op_o = ALU_OR;
        default: alu_op_o = ALU_AND;
      endcase
    end
  end
endmodule

// File: rtl/rv_field_decoder.sv
module rv_field_decoder
  import rv_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ILEN-1:0]   instr_i,
  output logic [RIDX_W-1:0] rd_o,
  output logic [RIDX_W-1:0] rs1_o,
  output logic [RIDX_W-1:0] rs2_o,
  output logic [ALU_W-1:0]  alu_op_o,
  output logic              neg_b_o,
  output logic              cmp_signed_o,
  output logic [ILEN-1:0]   imm_o,
  output logic [FMT_W-1:0]  fmt_o,
  output logic              illegal_o
);
  fmt_e              fmt_c;
  logic              is_op_c, is_opimm_c;
  logic [RIDX_W-1:0] idx_c [3];
  logic [ILEN-1:0]   imm_c;
  logic [ALU_W-1:0]  alu_c;
  logic              negb_c, csgn_c;

  rv_fmt_classify u_cls (
    .opcode_i   (instr_i[OPC_W-1:0]),
    .fmt_o      (fmt_c),
    .is_op_o    (is_op_c),
    .is_opimm_o (is_opimm_c)
  );

  rv_reg_fields #(.NFIELD(3)) u_regs (
    .body_i (instr_i[24:7]),
    .fmt_i  (fmt_c),
    .idx_o  (idx_c)
  );

  rv_imm_build u_imm (
    .ins_i (instr_i[ILEN-1:7]),
    .fmt_i (fmt_c),
    .imm_o (imm_c)
  );

  rv_alu_map u_alu (
    .is_op_i      (is_op_c),
    .is_opimm_i   (is_opimm_c),
    .funct3_i     (instr_i[14:12]),
    .alt_i        (instr_i[30]),
    .alu_op_o     (alu_c),
    .neg_b_o      (negb_c),
    .cmp_signed_o (csgn_c)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_o         <= '0;
      rs1_o        <= '0;
      rs2_o        <= '0;
      alu_op_o     <= '0;
      neg_b_o      <= 1'b0;
      cmp_signed_o <= 1'b0;
      imm_o        <= '0;
      fmt_o        <= FMT_NONE;
      illegal_o    <= 1'b0;
    end else begin
      rd_o         <= idx_c[0];
      rs1_o        <= idx_c[1];
      rs2_o        <= idx_c[2];
      alu_op_o     <= alu_c;
      neg_b_o      <= negb_c;
      cmp_signed_o <= csgn_c;
      imm_o        <= imm_c;
      fmt_o        <= fmt_c;
      illegal_o    <= (fmt_c == FMT_NONE);
    end
  end
endmodule

// File: rtl/rv_field_decoder_chk.sv
module rv_field_decoder_chk
  import rv_dec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_i,
  input logic [ILEN-1:0]   instr_i,
  input logic [RIDX_W-1:0] rd_o,
  input logic [RIDX_W-1:0] rs1_o,
  input logic [RIDX_W-1:0] rs2_o,
  input logic [ALU_W-1:0]  alu_op_o,
  input logic              neg_b_o,
  input logic              cmp_signed_o,
  input logic [ILEN-1:0]   imm_o,
  input logic [FMT_W-1:0]  fmt_o,
  input logic              illegal_o
);
  a_r8_illegal_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    illegal_o |-> (fmt_o == 3'd0 && imm_o == '0 && rd_o == '0 && rs1_o == '0 &&
                   rs2_o == '0 && alu_op_o == '0 && !neg_b_o && !cmp_signed_o));

  a_r7_rtype_no_imm: assert property (@(posedge clk_i) disable iff (rst_i)
    (fmt_o == 3'd1) |-> (imm_o == '0));

  a_r7_upper_low_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    (fmt_o == 3'd5) |-> (imm_o[11:0] == 12'd0));

  a_r5_r6_even_offset: assert property (@(posedge clk_i) disable iff (rst_i)
    (fmt_o == 3'd4 || fmt_o == 3'd6) |-> !imm_o[0]);

  a_r2_rd_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && (fmt_o == 3'd1 || fmt_o == 3'd2 || fmt_o == 3'd5 || fmt_o == 3'd6))
      |-> (rd_o == $past(instr_i[11:7])));

  a_r1_opcode_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(instr_i[6:0]) == 7'b1101111) |-> (fmt_o == 3'd6));

  a_r3_sign_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && (fmt_o == 3'd2 || fmt_o == 3'd3)) |-> (imm_o[31] == $past(instr_i[31])));

  a_r9_negb_only_add: assert property (@(posedge clk_i) disable iff (rst_i)
    neg_b_o |-> (alu_op_o == 4'b0000 && fmt_o == 3'd1));
endmodule

bind rv_field_decoder rv_field_decoder_chk u_chk (.*);

// File: tb/sim_rv_field_decoder.sv
module sim_rv_field_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [4:0]  rd, rs1, rs2;
  logic [3:0]  aop;
  logic        negb, csgn, ill;
  logic [31:0] imm;
  logic [2:0]  fmt;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  rv_field_decoder u0 (
    .clk_i(clk), .rst_i(rst), .instr_i(instr),
    .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2), .alu_op_o(aop), .neg_b_o(negb),
    .cmp_signed_o(csgn), .imm_o(imm), .fmt_o(fmt), .illegal_o(ill)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (instr %h)", tag, act, exp, instr);
    end
  endtask

  // behavioural reference from the requirements
  task automatic expect_for(input logic [31:0] w);
    int f; int a; bit nb, cs;
    int signed iv;
    int uses_rd, uses_r1, uses_r2;
    int f3 = int'(w[14:12]);
    f = 0; a = 0; nb = 0; cs = 0; iv = 0;
    case (w[6:0])
      7'h33: f = 1;
      7'h13, 7'h03, 7'h67: f = 2;
      7'h23: f = 3;
      7'h63: f = 4;
      7'h37, 7'h17: f = 5;
      7'h6f: f = 6;
      default: f = 0;
    endcase
    // R1 / R8
    chk("R1 fmt", {29'd0, fmt}, f);
    chk("R8 illegal", {31'd0, ill}, (f == 0));
    uses_rd = (f == 1 || f == 2 || f == 5 || f == 6);
    uses_r1 = (f >= 1 && f <= 4);
    uses_r2 = (f == 1 || f == 3 || f == 4);
    chk("R2 rd",  {27'd0, rd},  uses_rd ? int'(w[11:7])  : 0);
    chk("R2 rs1", {27'd0, rs1}, uses_r1 ? int'(w[19:15]) : 0);
    chk("R2 rs2", {27'd0, rs2}, uses_r2 ? int'(w[24:20]) : 0);
    case (f)
      2: iv = $signed(w) >>> 20;                                          // R3
      3: iv = (($signed(w) >>> 25) * 32) + int'(w[11:7]);                 // R4
      4: iv = (($signed(w) >>> 31) * 4096) + int'(w[7]) * 2048 +
              int'(w[30:25]) * 32 + int'(w[11:8]) * 2;                    // R5
      5: iv = int'(w & 32'hFFFF_F000);                                    // R7
      6: iv = (($signed(w) >>> 31) * (1 << 20)) + int'(w[19:12]) * 4096 +
              int'(w[20]) * 2048 + int'(w[30:21]) * 2;                    // R6
      default: iv = 0;                                                    // R7 R-type, R8
    endcase
    chk(f == 2 ? "R3 imm" : f == 3 ? "R4 imm" : f == 4 ? "R5 imm" :
        f == 6 ? "R6 imm" : f == 0 ? "R8 imm" : "R7 imm", imm, iv);
    if (w[6:0] == 7'h33 || w[6:0] == 7'h13) begin
      case (f3)
        0: begin a = 0; nb = (w[6:0] == 7'h33) && w[30]; end
        1: a = 7;
        2: begin a = 2; cs = 1; end
        3: a = 2;
        4: a = 5;
        5: a = w[30] ? 9 : 8;
        6: a = 4;
        default: a = 3;
      endcase
    end
    chk(w[6:0] == 7'h33 ? "R9 aluop" : w[6:0] == 7'h13 ? "R10 aluop" : "R11 aluop", {28'd0, aop}, a);
    chk(w[6:0] == 7'h13 ? "R10 negb" : "R9 negb", {31'd0, negb}, nb);
    chk(f == 0 || !(w[6:0] inside {7'h33, 7'h13}) ? "R11 csgn" : "R10 csgn", {31'd0, csgn}, cs);
  endtask

  task automatic expect_reset();
    chk("R12 rst fmt", {29'd0, fmt}, 0);
    chk("R12 rst ill", {31'd0, ill}, 0);
    chk("R12 rst imm", imm, 0);
    chk("R12 rst regs", {17'd0, rd, rs1, rs2}, 0);
    chk("R12 rst alu", {26'd0, aop, negb, csgn}, 0);
  endtask

  // drive on a falling edge, check on the next falling edge (R12: one register)
  task automatic feed(input logic [31:0] w);
    instr = w;
    @(negedge clk);
    expect_for(w);
  endtask

  localparam logic [6:0] OPCS [12] = '{7'h33, 7'h13, 7'h03, 7'h67, 7'h23, 7'h63,
                                       7'h37, 7'h17, 7'h6f, 7'h73, 7'h0f, 7'h00};

  initial begin
    repeat (3) @(negedge clk);
    expect_reset();
    rst = 1'b0;
    feed(32'hFFF1_0093); // addi x1,x2,-1
    feed(32'h4031_81B3); // sub x3,x3,x3
    feed(32'h4020_D233); // sra
    feed(32'h4051_5293); // srai
    feed(32'h0020_A333); // slt
    feed(32'h0020_B333); // sltu
    feed(32'h0050_2313); // slti
    feed(32'hFE11_2E23); // sw negative offset
    feed(32'hFE00_0EE3); // beq negative offset
    feed(32'hABCD_E0B7); // lui
    feed(32'h1234_5097); // auipc
    feed(32'hFFDF_F0EF); // jal negative
    feed(32'h8000_00EF); // jal most negative
    feed(32'h0000_8067); // jalr
    feed(32'h8001_2183); // lw min offset
    feed(32'h4000_0013); // addi with bit30 set: no negate
    feed(32'h0000_0073); // unlisted opcode
    feed(32'hFFFF_FFFF); // unlisted opcode, all ones
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w = $urandom();
      w[6:0] = OPCS[$urandom_range(0, 11)];
      feed(w);
    end
    // mid-run reset (R12)
    instr = 32'hFFF1_0093;
    rst = 1'b1;
    @(negedge clk);
    expect_reset();
    rst = 1'b0;
    feed(32'hFE11_2E23);
    feed(32'h0000_0033);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule